// File: doc/BRIEF.md
# Dual-Channel Tamper Detection Register

This block watches two external tamper switches. Each switch has its own input pin and its own control register. A control register enables the channel, enables its interrupt, and describes how the switch is wired. The wiring is described by two bits: whether the switch is normally open or normally closed, and whether it is referenced to ground or to supply. Together these two bits fix the pin level that counts as a tamper condition.

Each pin passes through a two-flop synchroniser. When an enabled channel sees its active level, it latches a sticky flag. Software reads the flags through a flags register. The only way to clear a flag is to write the channel's enable bit to zero.

A flag that becomes set can also drive an active-low interrupt line, provided that channel's interrupt is enabled. While the system runs on battery, the interrupt is raised only if a separate alarm-in-battery enable input is also high. Once raised, the interrupt holds until the flag that caused it is cleared or the flags register is read.

Top module: `tamper_regs`

## Requirements
- R1: After a synchronous reset, all control bits and both flags read 0, and `irq_n` is 1.
- R2: A channel's flag becomes 1 on the third rising clock edge after its pin first shows the active level, and only if the channel's enable bit is 1 at that edge. A disabled channel never sets its flag.
- R3: A set flag stays 1 for as long as its enable bit stays 1, whatever the pin does. A write to address 0x0F changes nothing. A flag clears on the edge after the enable bit reads 0.
- R4: The active pin level is mode XOR polarity. The mode bit is 0 for a normally-open switch and 1 for a normally-closed switch. The polarity bit is 0 for a ground-referenced switch and 1 for a supply-referenced switch.
- R5: Channel 1 control is at 0x14 and channel 2 control is at 0x15. In each, bit 3 is enable, bit 2 is interrupt enable, bit 1 is mode and bit 0 is polarity, and bits 7:4 read 0. Address 0x0F holds flag 1 in bit 0 and flag 2 in bit 1, with all other bits 0. Unmapped addresses read 0. Read data is combinational on `addr`.
- R6: When a flag goes from 0 to 1 with its interrupt-enable bit set, `irq_n` goes low in the same cycle the flag appears. It stays low until that flag is cleared, or until a read strobe (`rd_en`) is given at 0x0F. A flag setting with its interrupt enable at 0 leaves `irq_n` high.
- R7: While `batt_mode` is 1, a flag setting raises the interrupt only if `alarm_batt_en` is 1. Otherwise the flag still sets but `irq_n` stays high.
- R8: The two channels are independent. Writes, pin activity and flag clears on one channel leave the other channel's control bits, flag and interrupt state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (acknowledges the interrupt at 0x0F) |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tamper_pin | input | 2 | Raw tamper switch pins, bit 0 = channel 1 |
| batt_mode | input | 1 | System is running on battery |
| alarm_batt_en | input | 1 | Allow the interrupt while on battery |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench counts the synchroniser latency exactly: a design with one stage too many or too few shifts the flag by a cycle, and the per-clock comparison catches it. All four mode and polarity combinations are driven with both pin levels, so an inverted or ignored polarity sets the flag at the idle level instead of the active one. The bench writes ones to the flags address and toggles the pin back while a channel stays enabled; a design that lets a flag be written or lets it follow the pin would drop it. On the interrupt path, the bench checks the battery gating and the acknowledge given by a read of 0x0F. It also sets a flag while that channel's interrupt enable is off, and a design that raises `irq_n` on the flag level instead of on the set event would then fire.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int N_CH     = 2;
    localparam int CTL_W    = 4;
    localparam logic [ADDR_W-1:0] FLAGS_ADDR = 8'h0F;
    localparam logic [ADDR_W-1:0] CTL_BASE   = 8'h14;

    // Packed so bit 3 = enable, 2 = irq enable, 1 = mode, 0 = polarity
    typedef struct packed {
        logic en;
        logic ie;
        logic mode;   // 0 normally open, 1 normally closed
        logic pol;    // 0 ground referenced, 1 supply referenced
    } ctl_t;

    function automatic logic active_level(input ctl_t c);
        return c.mode ^ c.pol;
    endfunction

    function automatic logic [ADDR_W-1:0] ctl_addr(input int ch);
        return CTL_BASE + ADDR_W'(ch);
    endfunction
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
    import tamper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  ctl_t ctl_wdata,
    input  logic pin_sync,
    input  logic irq_allow,
    input  logic flags_rd,
    output ctl_t ctl,
    output logic flag,
    output logic pend
);
    logic hit;
    logic set_evt;
    logic flag_nxt;

    always_comb begin
        hit      = ctl.en && (pin_sync == active_level(ctl));
        set_evt  = hit && !flag;
        flag_nxt = ctl.en ? (flag || hit) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            flag <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (ctl_wr) ctl <= ctl_wdata;
            flag <= flag_nxt;
            if (set_evt && ctl.ie && irq_allow) pend <= 1'b1;
            else if (!flag_nxt || flags_rd)     pend <= 1'b0;
        end
    end

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ctl.en)); // R2
    AST_FLAG_CLR_ON_DIS: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !flag); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && ctl.en) |=> flag); // R3
    AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(ctl.ie) && $rose(flag))); // R6
endmodule

// File: rtl/tamper_regs.sv
module tamper_regs
    import tamper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_CH-1:0]   tamper_pin,
    input  logic              batt_mode,
    input  logic              alarm_batt_en,
    output logic              irq_n
);
    ctl_t            ctl  [N_CH];
    logic [N_CH-1:0] flag;
    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] pin_s;
    logic            irq_allow;
    logic            flags_rd;

    assign irq_allow = !batt_mode || alarm_batt_en;
    assign flags_rd  = rd_en && (addr == FLAGS_ADDR);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tamper_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (tamper_pin[i]),
            .q   (pin_s[i])
        );

        tamper_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .ctl_wr    (wr_en && (addr == ctl_addr(i))),
            .ctl_wdata (ctl_t'(wdata[CTL_W-1:0])),
            .pin_sync  (pin_s[i]),
            .irq_allow (irq_allow),
            .flags_rd  (flags_rd),
            .ctl       (ctl[i]),
            .flag      (flag[i]),
            .pend      (pend[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == FLAGS_ADDR) rdata[N_CH-1:0] = flag;
        for (int i = 0; i < N_CH; i++)
            if (addr == ctl_addr(i)) rdata[CTL_W-1:0] = ctl[i];
    end

    assign irq_n = ~|pend;

    AST_BATT_GATE: assert property (@(posedge clk) disable iff (rst)
        ($past(batt_mode) && !$past(alarm_batt_en) && $past(irq_n)) |-> irq_n); // R7
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (|flag)); // R6
endmodule

// File: tb/sim_tamper_regs.sv
module sim_tamper_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] addr = 8'h0F, wdata = 0;
    logic [7:0] rdata;
    logic [1:0] tamper_pin = 2'b11;
    logic       batt_mode = 0, alarm_batt_en = 0;
    logic       irq_n;

    int    vectors = 0, miscompares = 0;
    string phase = "R1";
    bit    done = 0;

    // behavioural model state
    int m_ctl[2], m_flag[2], m_pend[2], m_s1[2], m_s2[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    tamper_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tamper_pin(tamper_pin),
        .batt_mode(batt_mode), .alarm_batt_en(alarm_batt_en), .irq_n(irq_n)
    );

    function automatic int exp_rdata();
        if (addr == 8'h0F) return m_flag[0] | (m_flag[1] << 1);
        if (addr == 8'h14) return m_ctl[0];
        if (addr == 8'h15) return m_ctl[1];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_ctl[c] = 0; m_flag[c] = 0; m_pend[c] = 0; m_s1[c] = 0; m_s2[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int en, ie, act, hit, nf, evt;
                en  = (m_ctl[c] >> 3) & 1;
                ie  = (m_ctl[c] >> 2) & 1;
                act = ((m_ctl[c] >> 1) & 1) ^ (m_ctl[c] & 1);
                hit = en && (m_s2[c] == act);
                evt = hit && !m_flag[c];
                nf  = en ? (m_flag[c] || hit) : 0;
                if (evt && ie && (!batt_mode || alarm_batt_en)) m_pend[c] = 1;
                else if (!nf || (rd_en && addr == 8'h0F))      m_pend[c] = 0;
                m_flag[c] = nf;
                m_s2[c] = m_s1[c];
                m_s1[c] = tamper_pin[c];
                if (wr_en && addr == 8'h14 + c) m_ctl[c] = wdata[3:0];
            end
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            vectors++;
            if (rdata !== 8'(exp_rdata())) begin
                miscompares++;
                $display("FAIL %s rdata addr=%h actual=%h expected=%h", phase, addr, rdata, exp_rdata());
            end
            vectors++;
            if (irq_n !== !(m_pend[0] || m_pend[1])) begin
                miscompares++;
                $display("FAIL %s irq_n actual=%b expected=%b", phase, irq_n, !(m_pend[0] || m_pend[1]));
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 0; rd_en = 0; addr = 8'h0F;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; rd_en = 0; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = 8'h0F;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        rd_en = 1; wr_en = 0; addr = a;
        @(negedge clk);
        rd_en = 0; addr = 8'h0F;
    endtask

    task automatic show(logic [7:0] a);
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = a;
    endtask

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        show(8'h14); show(8'h15); show(8'h0F);

        phase = "R5";
        wr(8'h14, 8'hF5); show(8'h14);
        wr(8'h15, 8'hA2); show(8'h15);
        show(8'h33); show(8'h16);
        wr(8'h14, 8'h00); wr(8'h15, 8'h00); idle(2);

        phase = "R2";  // disabled channel ignores active level
        tamper_pin = 2'b00; idle(5);
        tamper_pin = 2'b11; idle(3);
        wr(8'h14, 8'h08);            // enable, NO to ground: active 0
        idle(4);
        @(negedge clk) tamper_pin[0] = 0;
        idle(5);

        phase = "R3";
        @(negedge clk) tamper_pin[0] = 1;
        idle(4);
        wr(8'h0F, 8'h00); idle(2);
        wr(8'h0F, 8'hFF); idle(2);
        wr(8'h14, 8'h00); idle(3);

        phase = "R4";
        for (int m = 0; m < 4; m++) begin
            int act;
            act = (m >> 1) ^ (m & 1);
            @(negedge clk) tamper_pin[1] = !act;
            idle(3);
            wr(8'h15, 8'h08 | m); idle(4);
            @(negedge clk) tamper_pin[1] = act;
            idle(4);
            wr(8'h15, 8'h00); idle(2);
        end

        phase = "R6";
        tamper_pin = 2'b11;
        wr(8'h14, 8'h0C); idle(3);
        @(negedge clk) tamper_pin[0] = 0;
        idle(5);
        rd(8'h14); idle(2);           // read elsewhere does not acknowledge
        rd(8'h0F); idle(3);           // acknowledge
        wr(8'h14, 8'h00); idle(2);
        tamper_pin[0] = 1; idle(3);
        wr(8'h14, 8'h0C); idle(2);
        @(negedge clk) tamper_pin[0] = 0;
        idle(5);
        wr(8'h14, 8'h00); idle(3);    // clearing flag drops irq
        tamper_pin[0] = 1; idle(3);
        wr(8'h14, 8'h08); idle(2);    // ie off
        @(negedge clk) tamper_pin[0] = 0;
        idle(4);
        wr(8'h14, 8'h0C); idle(4);    // ie on after the set: no irq
        wr(8'h14, 8'h00); tamper_pin[0] = 1; idle(3);

        phase = "R7";
        batt_mode = 1; alarm_batt_en = 0;
        wr(8'h15, 8'h0C); idle(2);
        @(negedge clk) tamper_pin[1] = 0;
        idle(5);
        wr(8'h15, 8'h00); tamper_pin[1] = 1; idle(3);
        alarm_batt_en = 1;
        wr(8'h15, 8'h0C); idle(2);
        @(negedge clk) tamper_pin[1] = 0;
        idle(5);
        rd(8'h0F); idle(2);
        wr(8'h15, 8'h00); tamper_pin[1] = 1; idle(3);
        batt_mode = 0; alarm_batt_en = 0;

        phase = "R8";
        wr(8'h14, 8'h0C); wr(8'h15, 8'h0F); idle(3);
        @(negedge clk) tamper_pin[0] = 0;
        idle(5);
        show(8'h15); show(8'h0F);
        @(negedge clk) tamper_pin[1] = 0;
        idle(5);
        wr(8'h15, 8'h00); idle(3);
        show(8'h14); show(8'h0F);
        wr(8'h14, 8'h00); idle(3);

        phase = "R1";
        @(negedge clk) rst = 1;
        idle(2);
        @(negedge clk) rst = 0;
        show(8'h14); show(8'h0F);
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule